// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block turns one packed command word into a complete transaction on a raw 8-bit NAND flash bus. The word names the first opcode, whether an address phase occurs and how many bytes it carries, the direction of an optional data phase, and which of two chip enables to drive. A separate opcode word can supply a second opcode. That opcode follows the address or write-data phase, so a two-opcode operation runs as a single hardware command. Examples are a page program with its confirm, an erase with its confirm, and a large-page read with its read-start.

Write data comes from a small internal page buffer and read data lands in it. The host fills and inspects the buffer through a plain byte port while the sequencer is idle. After the last opcode the sequencer lets a fixed write-to-busy window pass. It then waits for the ready/busy line to report ready, runs any read phase, and sets a completion flag in a write-one-to-clear status word. A command word that arrives while an operation is running is dropped and leaves a sticky error flag.

Top module: `nand_cmd_seq`

## Requirements
- R1: A command word starts an operation only when its bit 31 is set and the block is idle. A word with bit 31 clear causes no bus activity and no status change.
- R2: Every operation begins with the low byte of the command word driven as an opcode cycle: CLE high, ALE low, one WE# low pulse. CLE and ALE are never high together.
- R3: Bits 30:27 of the command word form the address field. Bit 30 enables the address phase, and bits 29:27 hold the byte count minus one. Counts above 5 are treated as 5. Address bytes go out with ALE high, least significant byte of the address input first.
- R4: When bit 25 is set and bit 26 is clear, the write phase drives the length-register count of bytes from page-buffer index 0 upward, one WE# pulse each. The data bus is never driven while RE# is low.
- R5: When bit 26 is set, the read phase takes place after the ready wait. It issues one RE# pulse per byte and stores the bytes at page-buffer index 0 upward. A length above the buffer depth is cut to the depth.
- R6: Bits 7:0 of the second-opcode word hold the opcode and bit 8 enables it. When enabled, it is sent as an opcode cycle after the address and any write phase. When disabled, no second opcode cycle appears.
- R7: Command-word bit 19 selects chip enable 1 (nf_ce_n_o[1] low) instead of chip enable 0 (nf_ce_n_o[0] low). Exactly one enable is low while busy, and both are high when idle.
- R8: After the final opcode's WE# rising edge, at least TWB_CYC clocks pass, and the ready/busy input must be high, before completion is flagged. While that input stays low the operation does not complete.
- R9: The status word carries bit 31 (operation done, set on every completion) and bit 28 (read transfer ended, set only when bit 26 was set). Writing a 1 to a status bit through the clear port clears it; a 0 leaves it.
- R10: A command word written while busy is ignored: the running operation's bus cycles are unchanged. It sets the sticky error bit 0 of the status word, which is cleared by writing 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctrl_we_i | input | 1 | Command word write strobe |
| ctrl_word_i | input | 32 | Command word |
| op2_word_i | input | 9 | Second opcode (7:0) and its enable (8), sampled at start |
| addr_i | input | 8*MAX_ADDR | Address bytes, byte 0 sent first, sampled at start |
| len_i | input | clog2(BUF_DEPTH+1) | Data phase byte count, sampled at start |
| buf_we_i | input | 1 | Host page-buffer write strobe |
| buf_addr_i | input | clog2(BUF_DEPTH) | Host page-buffer index |
| buf_wdata_i | input | 8 | Host page-buffer write byte |
| buf_rdata_o | output | 8 | Page-buffer byte at buf_addr_i |
| sts_clr_we_i | input | 1 | Status clear strobe |
| sts_clr_i | input | 32 | Status bits to clear (ones clear) |
| sts_o | output | 32 | Status word: 31 done, 28 read end, 0 error |
| busy_o | output | 1 | Operation in progress |
| irq_o | output | 1 | Any status bit set |
| nf_ce_n_o | output | 2 | Chip enables, active low |
| nf_cle_o | output | 1 | Command latch enable |
| nf_ale_o | output | 1 | Address latch enable |
| nf_we_n_o | output | 1 | Write strobe, active low |
| nf_re_n_o | output | 1 | Read strobe, active low |
| nf_dq_o | output | 8 | Data bus out |
| nf_dq_oe_o | output | 1 | Data bus output enable |
| nf_dq_i | input | 8 | Data bus in |
| nf_rb_i | input | 1 | Ready (1) / busy (0) |

## Verification
The bench uses the default parameters: a 16-byte buffer, 2-clock strobe halves, a 6-clock write-to-busy window and up to 5 address bytes. With 5 address bytes, the full address field, including the clamped encodings 6 to 8, shows up on the bus. The short buffer lets complete program, page-read and ID-read transfers be compared byte by byte in a few hundred clocks. Because the window is longer than a strobe half, a sequencer that skipped it would flag completion measurably too early.

// File: rtl/nfseq_pkg.sv
package nfseq_pkg;

    localparam int VALID_BIT  = 31;
    localparam int RD_BIT     = 26;
    localparam int WR_BIT     = 25;
    localparam int ACNT_LSB   = 27;
    localparam int CS_BIT     = 19;
    localparam int OP2_EN_BIT = 8;
    localparam int STS_DONE   = 31;
    localparam int STS_RDEND  = 28;
    localparam int STS_ERR    = 0;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CMD1,
        S_ADDR,
        S_WDATA,
        S_CMD2,
        S_TWB,
        S_WAITRB,
        S_RDATA
    } state_e;

    typedef struct packed {
        logic [7:0] opcode;
        logic       rd;
        logic       wr;
        logic       addr_en;
        logic [2:0] addr_cnt;
        logic       cs;
    } cmd_t;

endpackage

// File: rtl/nfseq_decode.sv
module nfseq_decode
    import nfseq_pkg::*;
#(
    parameter int MAX_ADDR = 5
) (
    input  logic [31:0] word_i,
    output cmd_t        cmd_o
);

    logic [2:0] raw_cnt;
    logic       unused_bits;

    assign raw_cnt     = word_i[ACNT_LSB+2:ACNT_LSB];
    assign unused_bits = ^{word_i[31], word_i[24:20], word_i[18:8]};

    always_comb begin
        cmd_o.opcode  = word_i[7:0];
        cmd_o.rd      = word_i[RD_BIT];
        cmd_o.wr      = word_i[WR_BIT] & ~word_i[RD_BIT];
        cmd_o.addr_en = word_i[ACNT_LSB+3];
        cmd_o.cs      = word_i[CS_BIT];
        if (int'(raw_cnt) >= MAX_ADDR) begin
            cmd_o.addr_cnt = 3'(MAX_ADDR);
        end else begin
            cmd_o.addr_cnt = raw_cnt + 3'd1;
        end
    end

endmodule

// File: rtl/nfseq_pagebuf.sv
module nfseq_pagebuf #(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk_i,
    input  logic          host_we_i,
    input  logic [AW-1:0] host_addr_i,
    input  logic [7:0]    host_wdata_i,
    output logic [7:0]    host_rdata_o,
    input  logic          seq_we_i,
    input  logic [AW-1:0] seq_addr_i,
    input  logic [7:0]    seq_wdata_i,
    output logic [7:0]    seq_rdata_o
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk_i) begin
        if (seq_we_i) begin
            mem[seq_addr_i] <= seq_wdata_i;
        end else if (host_we_i) begin
            mem[host_addr_i] <= host_wdata_i;
        end
    end

    assign host_rdata_o = mem[host_addr_i];
    assign seq_rdata_o  = mem[seq_addr_i];

endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
    import nfseq_pkg::*;
#(
    parameter int BUF_DEPTH = 16,
    parameter int STB_CYC   = 2,
    parameter int TWB_CYC   = 6,
    parameter int MAX_ADDR  = 5,
    parameter int BUF_AW    = $clog2(BUF_DEPTH),
    parameter int LEN_W     = $clog2(BUF_DEPTH + 1),
    parameter int ADDR_W    = 8 * MAX_ADDR
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ctrl_we_i,
    input  logic [31:0]       ctrl_word_i,
    input  logic [8:0]        op2_word_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic              buf_we_i,
    input  logic [BUF_AW-1:0] buf_addr_i,
    input  logic [7:0]        buf_wdata_i,
    output logic [7:0]        buf_rdata_o,
    input  logic              sts_clr_we_i,
    input  logic [31:0]       sts_clr_i,
    output logic [31:0]       sts_o,
    output logic              busy_o,
    output logic              irq_o,
    output logic [1:0]        nf_ce_n_o,
    output logic              nf_cle_o,
    output logic              nf_ale_o,
    output logic              nf_we_n_o,
    output logic              nf_re_n_o,
    output logic [7:0]        nf_dq_o,
    output logic              nf_dq_oe_o,
    input  logic [7:0]        nf_dq_i,
    input  logic              nf_rb_i
);

    localparam int CYC_LEN = 2 * STB_CYC;
    localparam int TMR_MAX = (CYC_LEN > TWB_CYC) ? CYC_LEN : TWB_CYC;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);
    localparam int CNT_W   = (LEN_W > 3) ? LEN_W : 3;
    localparam logic [TMR_W-1:0] CYC_LAST = TMR_W'(CYC_LEN - 1);
    localparam logic [TMR_W-1:0] STB_LAST = TMR_W'(STB_CYC - 1);
    localparam logic [TMR_W-1:0] TWB_LAST = TMR_W'(TWB_CYC - 1);

    typedef struct packed {
        state_e            state;
        cmd_t              cmd;
        logic [8:0]        op2;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
        logic [TMR_W-1:0]  tmr;
        logic [CNT_W-1:0]  cnt;
        logic              done;
        logic              rdend;
        logic              err;
    } regs_t;

    regs_t d, q;
    cmd_t  dec;

    logic             cyc_end;
    logic             low_half;
    logic             finish;
    logic             seq_we;
    logic [7:0]       seq_rdata;
    logic [7:0]       addr_byte;
    logic [LEN_W-1:0] len_eff;
    logic             wr_bus;
    logic             unused_clr;

    nfseq_decode #(.MAX_ADDR(MAX_ADDR)) u_dec (
        .word_i (ctrl_word_i),
        .cmd_o  (dec)
    );

    nfseq_pagebuf #(.DEPTH(BUF_DEPTH), .AW(BUF_AW)) u_buf (
        .clk_i        (clk_i),
        .host_we_i    (buf_we_i),
        .host_addr_i  (buf_addr_i),
        .host_wdata_i (buf_wdata_i),
        .host_rdata_o (buf_rdata_o),
        .seq_we_i     (seq_we),
        .seq_addr_i   (q.cnt[BUF_AW-1:0]),
        .seq_wdata_i  (nf_dq_i),
        .seq_rdata_o  (seq_rdata)
    );

    function automatic state_e after_data(input logic [8:0] o2);
        return o2[OP2_EN_BIT] ? S_CMD2 : S_TWB;
    endfunction

    function automatic state_e after_addr(input cmd_t c, input logic [LEN_W-1:0] n,
                                          input logic [8:0] o2);
        if (c.wr && (n != '0)) begin
            return S_WDATA;
        end
        return after_data(o2);
    endfunction

    assign cyc_end    = (q.tmr == CYC_LAST);
    assign low_half   = (q.tmr <= STB_LAST);
    assign len_eff    = (len_i > LEN_W'(BUF_DEPTH)) ? LEN_W'(BUF_DEPTH) : len_i;
    assign addr_byte  = 8'(q.addr >> {q.cnt, 3'b000});
    assign unused_clr = ^{sts_clr_i[30:29], sts_clr_i[27:1]};

    always_comb begin
        d      = q;
        seq_we = 1'b0;
        finish = 1'b0;

        if (sts_clr_we_i) begin
            d.done  = q.done  & ~sts_clr_i[STS_DONE];
            d.rdend = q.rdend & ~sts_clr_i[STS_RDEND];
            d.err   = q.err   & ~sts_clr_i[STS_ERR];
        end

        case (q.state)
            S_IDLE: begin
                if (ctrl_we_i && ctrl_word_i[VALID_BIT]) begin
                    d.cmd   = dec;
                    d.op2   = op2_word_i;
                    d.addr  = addr_i;
                    d.len   = len_eff;
                    d.tmr   = '0;
                    d.cnt   = '0;
                    d.state = S_CMD1;
                end
            end
            S_CMD1: begin
                if (cyc_end) begin
                    d.tmr   = '0;
                    d.cnt   = '0;
                    d.state = q.cmd.addr_en ? S_ADDR : after_addr(q.cmd, q.len, q.op2);
                end else begin
                    d.tmr = q.tmr + TMR_W'(1);
                end
            end
            S_ADDR: begin
                if (cyc_end) begin
                    d.tmr = '0;
                    if ((q.cnt + CNT_W'(1)) == CNT_W'(q.cmd.addr_cnt)) begin
                        d.cnt   = '0;
                        d.state = after_addr(q.cmd, q.len, q.op2);
                    end else begin
                        d.cnt = q.cnt + CNT_W'(1);
                    end
                end else begin
                    d.tmr = q.tmr + TMR_W'(1);
                end
            end
            S_WDATA: begin
                if (cyc_end) begin
                    d.tmr = '0;
                    if ((q.cnt + CNT_W'(1)) == CNT_W'(q.len)) begin
                        d.cnt   = '0;
                        d.state = after_data(q.op2);
                    end else begin
                        d.cnt = q.cnt + CNT_W'(1);
                    end
                end else begin
                    d.tmr = q.tmr + TMR_W'(1);
                end
            end
            S_CMD2: begin
                if (cyc_end) begin
                    d.tmr   = '0;
                    d.state = S_TWB;
                end else begin
                    d.tmr = q.tmr + TMR_W'(1);
                end
            end
            S_TWB: begin
                if (q.tmr == TWB_LAST) begin
                    d.tmr   = '0;
                    d.state = S_WAITRB;
                end else begin
                    d.tmr = q.tmr + TMR_W'(1);
                end
            end
            S_WAITRB: begin
                if (nf_rb_i) begin
                    if (q.cmd.rd && (q.len != '0)) begin
                        d.tmr   = '0;
                        d.cnt   = '0;
                        d.state = S_RDATA;
                    end else begin
                        finish = 1'b1;
                    end
                end
            end
            S_RDATA: begin
                if (q.tmr == STB_LAST) begin
                    seq_we = 1'b1;
                end
                if (cyc_end) begin
                    d.tmr = '0;
                    if ((q.cnt + CNT_W'(1)) == CNT_W'(q.len)) begin
                        finish = 1'b1;
                    end else begin
                        d.cnt = q.cnt + CNT_W'(1);
                    end
                end else begin
                    d.tmr = q.tmr + TMR_W'(1);
                end
            end
            default: d.state = S_IDLE;
        endcase

        if (finish) begin
            d.state = S_IDLE;
            d.done  = 1'b1;
            if (q.cmd.rd) begin
                d.rdend = 1'b1;
            end
        end

        if (ctrl_we_i && (q.state != S_IDLE)) begin
            d.err = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign wr_bus     = (q.state == S_CMD1) || (q.state == S_ADDR) ||
                        (q.state == S_WDATA) || (q.state == S_CMD2);
    assign busy_o     = (q.state != S_IDLE);
    assign nf_cle_o   = (q.state == S_CMD1) || (q.state == S_CMD2);
    assign nf_ale_o   = (q.state == S_ADDR);
    assign nf_we_n_o  = ~(wr_bus && low_half);
    assign nf_re_n_o  = ~((q.state == S_RDATA) && low_half);
    assign nf_dq_oe_o = wr_bus;
    assign nf_ce_n_o  = !busy_o ? 2'b11 : (q.cmd.cs ? 2'b01 : 2'b10);
    assign sts_o      = {q.done, 2'b00, q.rdend, 27'd0, q.err};
    assign irq_o      = q.done | q.rdend | q.err;

    always_comb begin
        case (q.state)
            S_CMD1:  nf_dq_o = q.cmd.opcode;
            S_ADDR:  nf_dq_o = addr_byte;
            S_WDATA: nf_dq_o = seq_rdata;
            S_CMD2:  nf_dq_o = q.op2[7:0];
            default: nf_dq_o = 8'h00;
        endcase
    end

    // R7: at most one chip enable active
    a_r7_ce_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(~nf_ce_n_o)) else $error("a_r7_ce_onehot");

    // R7: idle releases both enables
    a_r7_idle_ce_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> (nf_ce_n_o == 2'b11)) else $error("a_r7_idle_ce_high");

    // R2: command and address latches exclusive
    a_r2_cle_ale_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(nf_cle_o && nf_ale_o)) else $error("a_r2_cle_ale_excl");

    // R4: no bus drive during a read strobe
    a_r4_no_drive_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !nf_re_n_o |-> !nf_dq_oe_o) else $error("a_r4_no_drive_on_read");

    // R8: busy flash holds the wait state
    a_r8_hold_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.state == S_WAITRB && !nf_rb_i) |=> (q.state == S_WAITRB))
        else $error("a_r8_hold_while_busy");

    // R9: completion coincides with return to idle
    a_r9_done_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(sts_o[STS_DONE]) |-> !busy_o) else $error("a_r9_done_when_idle");

    // R10: write while busy raises the error flag
    a_r10_err_on_busy_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctrl_we_i && busy_o) |=> sts_o[STS_ERR]) else $error("a_r10_err_on_busy_write");

endmodule

// File: tb/tb_nand_cmd_seq.sv
`timescale 1ns/1ps
module tb_nand_cmd_seq;

    localparam int BUF_DEPTH = 16;
    localparam int STB_CYC   = 2;
    localparam int TWB_CYC   = 6;
    localparam int MAX_ADDR  = 5;
    localparam int BUF_AW    = $clog2(BUF_DEPTH);
    localparam int LEN_W     = $clog2(BUF_DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctrl_we = 1'b0;
    logic [31:0] ctrl_word = '0;
    logic [8:0] op2_word = '0;
    logic [8*MAX_ADDR-1:0] addr = '0;
    logic [LEN_W-1:0] len = '0;
    logic buf_we = 1'b0;
    logic [BUF_AW-1:0] buf_addr = '0;
    logic [7:0] buf_wdata = '0;
    logic [7:0] buf_rdata;
    logic sts_clr_we = 1'b0;
    logic [31:0] sts_clr = '0;
    logic [31:0] sts;
    logic busy, irq;
    logic [1:0] nf_ce_n;
    logic nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe;
    logic [7:0] nf_dq, nf_dq_in;
    logic nf_rb = 1'b1;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int last_we_cyc = 0;
    int done_cyc = 0;

    logic [9:0] log_v [64];
    logic [1:0] log_ce [64];
    int log_n = 0;
    bit log_en = 1'b0;
    logic [9:0] exp_v [64];
    int exp_n = 0;
    logic [7:0] rd_base = 8'h00;
    int rd_idx = 0;

    always #2 clk = ~clk;
    always @(negedge clk) cyc++;

    nand_cmd_seq #(.BUF_DEPTH(BUF_DEPTH), .STB_CYC(STB_CYC), .TWB_CYC(TWB_CYC),
                   .MAX_ADDR(MAX_ADDR)) dut (
        .clk_i(clk), .rst_ni(rst_n), .ctrl_we_i(ctrl_we), .ctrl_word_i(ctrl_word),
        .op2_word_i(op2_word), .addr_i(addr), .len_i(len), .buf_we_i(buf_we),
        .buf_addr_i(buf_addr), .buf_wdata_i(buf_wdata), .buf_rdata_o(buf_rdata),
        .sts_clr_we_i(sts_clr_we), .sts_clr_i(sts_clr), .sts_o(sts), .busy_o(busy),
        .irq_o(irq), .nf_ce_n_o(nf_ce_n), .nf_cle_o(nf_cle), .nf_ale_o(nf_ale),
        .nf_we_n_o(nf_we_n), .nf_re_n_o(nf_re_n), .nf_dq_o(nf_dq), .nf_dq_oe_o(nf_dq_oe),
        .nf_dq_i(nf_dq_in), .nf_rb_i(nf_rb)
    );

    // bus monitor: record each write-strobe rising edge
    always @(posedge nf_we_n) begin
        if (log_en && rst_n && log_n < 64) begin
            log_v[log_n]  = {nf_cle, nf_ale, nf_dq};
            log_ce[log_n] = nf_ce_n;
            log_n++;
            last_we_cyc = cyc;
        end
    end

    // flash read model
    always @(negedge nf_re_n) begin
        if (rst_n) begin
            nf_dq_in = rd_base + 8'(rd_idx);
            rd_idx++;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    function automatic logic [31:0] cw(input logic [7:0] op, input bit rd, input bit wr,
                                       input int acnt, input bit cs);
        logic [31:0] w;
        w = 32'h8000_0000 | 32'(op) | (32'(rd) << 26) | (32'(wr) << 25) | (32'(cs) << 19);
        if (acnt > 0) w = w | (32'((acnt - 1) | 8) << 27);
        return w;
    endfunction

    function automatic logic [9:0] e_cmd(input logic [7:0] v); return {2'b10, v}; endfunction
    function automatic logic [9:0] e_adr(input logic [7:0] v); return {2'b01, v}; endfunction
    function automatic logic [9:0] e_dat(input logic [7:0] v); return {2'b00, v}; endfunction

    task automatic push(input logic [9:0] v);
        exp_v[exp_n] = v;
        exp_n++;
    endtask

    task automatic start(input logic [31:0] w, input logic [8:0] o2,
                         input logic [39:0] a, input int n);
        @(negedge clk);
        log_n = 0; exp_n = 0; log_en = 1'b1; rd_idx = 0;
        ctrl_word = w; op2_word = o2; addr = a; len = LEN_W'(n); ctrl_we = 1'b1;
        @(negedge clk);
        ctrl_we = 1'b0;
    endtask

    task automatic wait_done(input string req);
        bit seen = 1'b0;
        for (int k = 0; k < 3000 && !seen; k++) begin
            @(posedge clk); #1;
            if (sts[31]) begin seen = 1'b1; done_cyc = cyc; end
        end
        chk(seen, req, 64'(sts), 64'h8000_0000);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clr(input logic [31:0] m);
        @(negedge clk); sts_clr = m; sts_clr_we = 1'b1;
        @(negedge clk); sts_clr_we = 1'b0;
    endtask

    task automatic load_buf(input int idx, input logic [7:0] v);
        @(negedge clk); buf_addr = BUF_AW'(idx); buf_wdata = v; buf_we = 1'b1;
        @(negedge clk); buf_we = 1'b0;
    endtask

    task automatic peek_buf(input int idx, output logic [7:0] v);
        @(negedge clk); buf_addr = BUF_AW'(idx); #1; v = buf_rdata;
    endtask

    task automatic cmp_log(input string req, input logic [1:0] ce_exp);
        chk(log_n == exp_n, req, 64'(log_n), 64'(exp_n));
        for (int i = 0; i < exp_n && i < log_n; i++) begin
            chk(log_v[i] == exp_v[i], req, 64'(log_v[i]), 64'(exp_v[i]));
            chk(log_ce[i] == ce_exp, {req, " R7"}, 64'(log_ce[i]), 64'(ce_exp));
        end
    endtask

    task automatic t_reset;
        chk(sts == 32'h0, "R9 reset status", 64'(sts), 0);
        chk(!busy, "R1 reset idle", 64'(busy), 0);
        chk(nf_ce_n == 2'b11, "R7 reset enables", 64'(nf_ce_n), 3);
        chk(nf_we_n && nf_re_n, "R2 reset strobes", 64'({nf_we_n, nf_re_n}), 3);
    endtask

    task automatic t_program;
        for (int i = 0; i < 4; i++) load_buf(i, 8'hA0 + 8'(i));
        start(cw(8'h80, 0, 1, 5, 0), 9'h110, 40'h05_0403_0201, 4);
        wait_done("R8 program done");
        push(e_cmd(8'h80));
        for (int i = 1; i <= 5; i++) push(e_adr(8'(i)));
        for (int i = 0; i < 4; i++) push(e_dat(8'hA0 + 8'(i)));
        push(e_cmd(8'h10));
        cmp_log("R2 R3 R4 R6 program bus", 2'b10);
        chk(done_cyc - last_we_cyc >= TWB_CYC, "R8 write-to-busy window",
            64'(done_cyc - last_we_cyc), 64'(TWB_CYC));
        chk(sts == 32'h8000_0000, "R9 program status", 64'(sts), 64'h8000_0000);
        clr(32'hFFFF_FFFF);
        chk(sts == 32'h0, "R9 clear all", 64'(sts), 0);
    endtask

    task automatic t_read_page;
        logic [7:0] v;
        rd_base = 8'h40;
        start(cw(8'h00, 1, 0, 5, 1), 9'h130, 40'h11_2233_4455, 6);
        wait_done("R5 read done");
        push(e_cmd(8'h00));
        push(e_adr(8'h55)); push(e_adr(8'h44)); push(e_adr(8'h33));
        push(e_adr(8'h22)); push(e_adr(8'h11));
        push(e_cmd(8'h30));
        cmp_log("R3 R6 read page bus", 2'b01);
        for (int i = 0; i < 6; i++) begin
            peek_buf(i, v);
            chk(v == 8'h40 + 8'(i), "R5 read data", 64'(v), 64'(8'h40 + 8'(i)));
        end
        chk(sts == 32'h9000_0000, "R9 read status", 64'(sts), 64'h9000_0000);
        chk(irq, "R9 irq", 64'(irq), 1);
        clr(32'h1000_0000);
        chk(sts == 32'h8000_0000, "R9 partial clear", 64'(sts), 64'h8000_0000);
        clr(32'h8000_0000);
    endtask

    task automatic t_read_id;
        logic [7:0] v;
        rd_base = 8'h98;
        start(cw(8'h90, 1, 0, 1, 0), 9'h030, 40'h00_0000_0000, 4);
        wait_done("R5 id done");
        push(e_cmd(8'h90)); push(e_adr(8'h00));
        cmp_log("R6 id bus without second opcode", 2'b10);
        for (int i = 0; i < 4; i++) begin
            peek_buf(i, v);
            chk(v == 8'h98 + 8'(i), "R5 id data", 64'(v), 64'(8'h98 + 8'(i)));
        end
        clr(32'hFFFF_FFFF);
    endtask

    task automatic t_addr_field;
        start(32'h8000_0000 | (32'hF << 27) | 32'h05, 9'h0, 40'hE5_E4E3_E2E1, 0);
        wait_done("R3 clamp done");
        push(e_cmd(8'h05));
        for (int i = 1; i <= 5; i++) push(e_adr(8'hE0 + 8'(i)));
        cmp_log("R3 clamped count", 2'b10);
        clr(32'hFFFF_FFFF);
        start(cw(8'hFF, 0, 0, 0, 0), 9'h0, 40'h0, 0);
        wait_done("R3 no address done");
        push(e_cmd(8'hFF));
        cmp_log("R3 no address phase", 2'b10);
        clr(32'hFFFF_FFFF);
    endtask

    task automatic t_busy_flash;
        nf_rb = 1'b0;
        start(cw(8'h60, 0, 0, 3, 0), 9'h1D0, 40'h00_0007_0809, 0);
        idle(80);
        chk(!sts[31], "R8 no done while busy", 64'(sts), 0);
        chk(busy, "R8 still running", 64'(busy), 1);
        nf_rb = 1'b1;
        wait_done("R8 done after ready");
        push(e_cmd(8'h60)); push(e_adr(8'h09)); push(e_adr(8'h08)); push(e_adr(8'h07));
        push(e_cmd(8'hD0));
        cmp_log("R6 erase pair", 2'b10);
        clr(32'hFFFF_FFFF);
    endtask

    task automatic t_invalid;
        start(cw(8'h70, 0, 0, 1, 0) & 32'h7FFF_FFFF, 9'h0, 40'h0, 0);
        idle(40);
        chk(log_n == 0, "R1 no bus activity", 64'(log_n), 0);
        chk(!busy && sts == 32'h0, "R1 no status", 64'(sts), 0);
    endtask

    task automatic t_busy_write;
        rd_base = 8'h10;
        start(cw(8'h90, 1, 0, 1, 0), 9'h0, 40'h0, 2);
        idle(3);
        @(negedge clk); ctrl_word = cw(8'h70, 1, 0, 1, 1); ctrl_we = 1'b1;
        @(negedge clk); ctrl_we = 1'b0;
        wait_done("R10 first op done");
        push(e_cmd(8'h90)); push(e_adr(8'h00));
        cmp_log("R10 ignored write", 2'b10);
        chk(sts == 32'h9000_0001, "R10 error flag", 64'(sts), 64'h9000_0001);
        clr(32'h0000_0001);
        chk(sts == 32'h9000_0000, "R10 error cleared only", 64'(sts), 64'h9000_0000);
        clr(32'hFFFF_FFFF);
        chk(sts == 32'h0, "R9 all cleared", 64'(sts), 0);
    endtask

    initial begin
        #400000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        idle(3);
        #1 t_reset();
        @(negedge clk); rst_n = 1'b1;
        idle(2);
        t_reset();
        t_program();
        t_read_page();
        t_read_id();
        t_addr_field();
        t_busy_flash();
        t_invalid();
        t_busy_write();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule